// File: doc/BRIEF.md
# Gapless Serial Word Transmitter

This block turns parallel words into a bit stream on one serial data line. It sends one bit per system clock, most significant bit first. A one-word holding buffer sits in front of the shift register. A second word can therefore be handed over while the first is still being sent, and it follows the first with no idle cycle between them.

The producer offers a word by raising a one-cycle strobe while the ready flag is high. Ready depends only on whether the holding buffer is occupied, not on whether a shift is in progress. It drops in the cycle after a word has been parked in the buffer. It rises again as soon as that word moves into the shift register. A transmitting flag is high in every cycle in which a valid bit is on the line. While that flag is low, the line is held at 0. Chip select, serial clock generation and any receive path belong to the surrounding logic.

Top module: `ser_word_tx`

## Requirements
- R1: Each word is sent one bit per clock cycle, starting with bit WIDTH-1 and ending with bit 0.
- R2: A strobe taken while idle makes busy_o high in the next cycle, with bit WIDTH-1 of the word on sdo_o.
- R3: For a single word, busy_o is high for exactly WIDTH consecutive cycles and is low in the cycle that follows.
- R4: While a word is shifting and the holding buffer is empty, ready_o stays high.
- R5: A strobe taken while a word is shifting, other than in its final bit cycle, parks the word in the holding buffer, and ready_o is low from the next cycle.
- R6: A parked word starts in the cycle right after the last bit of the current word, and busy_o stays high across the boundary.
- R7: ready_o returns high in the same cycle in which the parked word's first bit appears on sdo_o.
- R8: While rst_n is low and after it is released, ready_o is high and busy_o and sdo_o are low.
- R9: A strobe seen while ready_o is low is ignored, and the parked word is sent unchanged.
- R10: While busy_o is low, sdo_o is 0.
- R11: A strobe taken in the final bit cycle of a word while the buffer is empty loads that word directly behind the current one, with no gap, and ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset that clears all state |
| word_i | input | WIDTH | Parallel word offered for sending |
| strobe_i | input | 1 | One-cycle request; taken when ready_o is high |
| ready_o | output | 1 | High while the holding buffer is empty |
| busy_o | output | 1 | High in every cycle that carries a valid bit |
| sdo_o | output | 1 | Serial data, MSB first; 0 while idle |

## Verification
The bench builds the block with WIDTH set to 4. At that width every 4-bit value can be sent on its own. Every pairing of a first and a second word can also be sent with the second strobe placed on each bit cycle of the first word. This covers all buffered placements as well as the final-cycle direct load. In every buffered case the strobe stays high with a different word while ready is low, so the sweep also shows that the parked word is never overwritten.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    typedef enum logic [1:0] {
        LOAD_NONE  = 2'd0,
        LOAD_INPUT = 2'd1,
        LOAD_HELD  = 2'd2
    } load_src_e;
endpackage

// File: rtl/sbt_shifter.sv
module sbt_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_word_i,
    output logic             busy_o,
    output logic             bit_o,
    output logic             final_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic [CW-1:0]    idx;
        logic             busy;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.word = load_word_i;
            state_d.idx  = '0;
            state_d.busy = 1'b1;
        end else if (state_q.busy) begin
            if (state_q.idx == LAST_IDX) begin
                state_d.word = '0;
                state_d.idx  = '0;
                state_d.busy = 1'b0;
            end else begin
                state_d.word = {state_q.word[WIDTH-2:0], 1'b0};
                state_d.idx  = state_q.idx + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o  = state_q.busy;
    assign bit_o   = state_q.busy & state_q.word[WIDTH-1];
    assign final_o = state_q.busy && (state_q.idx == LAST_IDX);
endmodule

// File: rtl/sbt_holdbuf.sv
module sbt_holdbuf #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             take_i,
    output logic             full_o,
    output logic [WIDTH-1:0] data_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             full;
    } hold_state_t;

    hold_state_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take_i) begin
            hold_d.full = 1'b0;
        end
        if (wr_i) begin
            hold_d.word = data_i;
            hold_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full_o = hold_q.full;
    assign data_o = hold_q.word;
endmodule

// File: rtl/sbt_sched.sv
module sbt_sched
    import sbt_pkg::*;
(
    input  logic      strobe_i,
    input  logic      held_full_i,
    input  logic      shift_busy_i,
    input  logic      shift_final_i,
    output load_src_e load_src_o,
    output logic      hold_wr_o,
    output logic      hold_take_o,
    output logic      ready_o
);
    logic accept;
    logic slot_free;

    always_comb begin
        ready_o     = ~held_full_i;
        accept      = strobe_i & ~held_full_i;
        // the shifter can take a new word at the next edge
        slot_free   = ~shift_busy_i | shift_final_i;
        load_src_o  = LOAD_NONE;
        hold_wr_o   = 1'b0;
        hold_take_o = 1'b0;
        if (slot_free) begin
            if (held_full_i) begin
                load_src_o  = LOAD_HELD;
                hold_take_o = 1'b1;
            end else if (accept) begin
                load_src_o = LOAD_INPUT;
            end
        end else if (accept) begin
            hold_wr_o = 1'b1;
        end
    end
endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx
    import sbt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] word_i,
    input  logic             strobe_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             sdo_o
);
    load_src_e        load_src;
    logic             hold_wr;
    logic             hold_take;
    logic             held_full;
    logic [WIDTH-1:0] held_word;
    logic             shift_final;
    logic             shift_load;
    logic [WIDTH-1:0] shift_word;

    sbt_sched u_sched (
        .strobe_i      (strobe_i),
        .held_full_i   (held_full),
        .shift_busy_i  (busy_o),
        .shift_final_i (shift_final),
        .load_src_o    (load_src),
        .hold_wr_o     (hold_wr),
        .hold_take_o   (hold_take),
        .ready_o       (ready_o)
    );

    sbt_holdbuf #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (hold_wr),
        .data_i (word_i),
        .take_i (hold_take),
        .full_o (held_full),
        .data_o (held_word)
    );

    always_comb begin
        shift_load = (load_src != LOAD_NONE);
        shift_word = (load_src == LOAD_HELD) ? held_word : word_i;
    end

    sbt_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (shift_load),
        .load_word_i (shift_word),
        .busy_o      (busy_o),
        .bit_o       (sdo_o),
        .final_o     (shift_final)
    );
endmodule

// File: rtl/ser_word_tx_chk.sv
module ser_word_tx_chk #(
    parameter int WIDTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic strobe_i,
    input logic ready_o,
    input logic busy_o,
    input logic sdo_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(WIDTH - 1);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (busy_o) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + CW'(1);
        end else begin
            pos_q <= '0;
        end
    end

    assert_idle_line_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sdo_o);

    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && ready_o && !busy_o) |=> busy_o);

    assert_word_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pos_q != LAST_POS) |=> busy_o);

    assert_held_gapless_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pos_q == LAST_POS && !ready_o) |=> busy_o);

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> ($past(strobe_i) && $past(busy_o)));

    assert_ready_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (busy_o && $past(pos_q) == LAST_POS));
endmodule

bind ser_word_tx ser_word_tx_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .ready_o  (ready_o),
    .busy_o   (busy_o),
    .sdo_o    (sdo_o)
);

// File: tb/ser_word_tx_test.sv
module ser_word_tx_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_i = '0;
    logic         strobe_i = 1'b0;
    logic         ready_o;
    logic         busy_o;
    logic         sdo_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    ser_word_tx #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_i   (word_i),
        .strobe_i (strobe_i),
        .ready_o  (ready_o),
        .busy_o   (busy_o),
        .sdo_o    (sdo_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic stb, input logic [W-1:0] w);
        strobe_i = stb;
        word_i   = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R8: during reset
        @(negedge clk);
        check("R8", "ready in reset", ready_o, 1'b1);
        check("R8", "busy in reset", busy_o, 1'b0);
        check("R8", "sdo in reset", sdo_o, 1'b0);
        step(1'b0, '0);
        rst_n = 1'b1;
        step(1'b0, '0);
        check("R8", "ready after reset", ready_o, 1'b1);
        check("R8", "busy after reset", busy_o, 1'b0);
        check("R10", "sdo idle", sdo_o, 1'b0);

        // single words: R1 R2 R3 R4 R10
        for (int v = 0; v < (1 << W); v++) begin
            step(1'b1, W'(v));
            for (int i = 0; i < W; i++) begin
                if (i > 0) step(1'b0, '0);
                check(i == 0 ? "R2" : "R1", "bit", sdo_o, v[W-1-i]);
                check("R3", "busy in word", busy_o, 1'b1);
                check("R4", "ready in word", ready_o, 1'b1);
            end
            step(1'b0, '0);
            check("R3", "busy after word", busy_o, 1'b0);
            check("R10", "sdo after word", sdo_o, 1'b0);
            step(1'b0, '0);
        end

        // pairs: second strobe at edge 1+k; k<W buffered (R5 R6 R7 R9), k==W direct (R11)
        for (int k = 1; k <= W; k++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    string rq;
                    step(1'b1, W'(a));
                    check("R2", "first bit", sdo_o, a[W-1]);
                    for (int c = 2; c <= 2 * W + 1; c++) begin
                        logic stb;
                        logic [W-1:0] w;
                        logic exp_rdy;
                        logic exp_busy;
                        logic exp_bit;
                        stb = 1'b0;
                        w   = '0;
                        if (c == 1 + k) begin
                            stb = 1'b1;
                            w   = W'(b);
                        end else if (k < W && c >= k + 2 && c <= W + 1) begin
                            stb = 1'b1;
                            w   = ~W'(b);
                        end
                        step(stb, w);
                        exp_rdy  = !(k < W && c >= k + 1 && c <= W);
                        exp_busy = (c <= 2 * W);
                        if (c <= W)          exp_bit = a[W-c];
                        else if (c <= 2 * W) exp_bit = b[2*W-c];
                        else                 exp_bit = 1'b0;
                        rq = (k == W) ? "R11" : ((c == W + 1) ? "R7" : ((c > W) ? "R9" : "R5"));
                        check(rq, "ready", ready_o, exp_rdy);
                        check((c == W + 1) ? "R6" : rq, "busy", busy_o, exp_busy);
                        check((c > W) ? rq : "R1", "bit", sdo_o, exp_bit);
                    end
                    step(1'b0, '0);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule